// File: doc/BRIEF.md
# Column Scan Control Sequencer

This block steps a scanning front end through a fixed schedule of control strobes with no processor involved. A step counter walks a schedule of 793 microsteps for each seat column. In one pass the block loads each substation's indicator byte from RAM into that substation's latch. It then writes the keypad row lines of every sub-substation into RAM, four bits per substation, with two substations packed into each byte. Next it waits a long dwell so the lights stay on, and then clears every substation latch. The final microstep raises a counter-reset bit and the next column begins.

After the last column of a frame the sequencer stops and keeps every strobe inactive. This gives the host time to move data in and out of the shared RAM. A one-cycle `host_release` pulse starts a new frame. The block also produces the RAM address for each access from the column and access indices. It drives the substation, pair and sub-substation selects used by the latch and multiplexer hardware. It reports the current phase so the lights-off latching can feed zeros to the latch bus.

Top module: `scan_sequencer`

## Requirements
- R1: A column pass lasts exactly 793 clocks (microsteps 0 to 792). The clock after microstep 792 is microstep 0 of the next column, and `col_idx` goes up by one.
- R2: Microsteps 0 to 23 load indicators. Substation k = step/4 is on `sub_sel`. In access sub-steps 0 to 2, CE and OE are low. In sub-step 2, `sub_latch` is high. In sub-step 3, everything is inactive. WE stays high.
- R3: The RAM strobes are active-low and idle high. WE is never low unless CE is also low. No strobe stays active from sub-step 3 of one four-step access into the next access.
- R4: Microsteps 24 to 119 are 24 keypad reads of four microsteps each. For read j = (step-24)/4, `pair_sel` = j/8 and `subsub_sel` = j%8. Pair p stores substation p in the low nibble and substation p+3 in the high nibble. `mux_en` is high for all four sub-steps. CE and WE are low in sub-steps 1 and 2. OE stays high.
- R5: Microsteps 120 to 127 (padding) and 128 to 767 (dwell) hold every strobe inactive, and `mux_en` and `sub_latch` are low.
- R6: Microsteps 768 to 791 clear the lights. `sub_sel` = (step-768)/4. `sub_latch` is high in sub-step 2. The RAM strobes stay idle.
- R7: `step_rst` is high on microstep 792 and on no other cycle.
- R8: While CE is low, `ram_addr` is col*6+k during indicator loads. During keypad reads it is N_COLS*6 + col*24 + j.
- R9: `cycle_done` is high only during microstep 792 of column N_COLS-1. On the next clock the block halts: `busy` is 0, `col_idx` is 0, and all control outputs are inactive.
- R10: While halted, `host_release` starts column 0, microstep 0 on the next clock. While running, `host_release` has no effect.
- R11: A synchronous active-high `rst` puts the block into the halted state with zero counters on the next clock. This holds whether the block was running or halted.
- R12: `phase` encodes halted=0, indicator load=1, keypad read=2, padding=3, dwell=4, lights off=5, reset step=6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_release | input | 1 | Host pulse that starts a frame while halted |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| sub_latch | output | 1 | Substation indicator latch pulse |
| mux_en | output | 1 | Keypad row multiplexer enable |
| step_rst | output | 1 | Step counter reset bit, last microstep |
| ram_addr | output | AW | RAM address, valid while CE is low |
| sub_sel | output | SUBW | Substation being latched |
| pair_sel | output | PW | Substation pair being captured |
| subsub_sel | output | SSW | Sub-substation being captured |
| col_idx | output | CW | Current column |
| phase | output | 3 | Current schedule phase |
| busy | output | 1 | High while columns are being scanned |
| cycle_done | output | 1 | High on the final microstep of a frame |

## Verification
The bench keeps the default schedule of six substations, eight sub-substations, four-clock accesses and a 640-step dwell, so every microstep boundary is checked at its true position. N_COLS is set to 3 instead of 48. This brings the end-of-frame halt, the idle wait, a second release and a reset in mid-column within a few thousand clocks. It also moves the keypad region base to 18, so the address check exercises the parameter-derived offset rather than a fixed constant.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

    typedef enum logic [2:0] {
        PH_HALT  = 3'd0,
        PH_LED   = 3'd1,
        PH_KEY   = 3'd2,
        PH_PAD   = 3'd3,
        PH_DWELL = 3'd4,
        PH_OFF   = 3'd5,
        PH_END   = 3'd6
    } scan_phase_e;

    typedef struct packed {
        logic we_n;
        logic ce_n;
        logic oe_n;
        logic latch;
        logic mux_en;
        logic step_rst;
    } scan_ctrl_t;

    localparam scan_ctrl_t CTRL_IDLE = '{
        we_n: 1'b1, ce_n: 1'b1, oe_n: 1'b1,
        latch: 1'b0, mux_en: 1'b0, step_rst: 1'b0
    };

    // Total schedule length for one column.
    function automatic int sched_len(int n_sub, int n_subsub, int acc_len,
                                     int pad, int dwell);
        return n_sub * acc_len                       // indicator loads
             + (n_sub / 2) * n_subsub * acc_len      // keypad reads
             + pad + dwell
             + n_sub * acc_len                       // lights off
             + 1;                                    // counter reset step
    endfunction

    // Read from RAM onto the latch bus, latch one step before release.
    function automatic scan_ctrl_t led_load_ctrl(int sub, int acc_len);
        scan_ctrl_t c;
        c = CTRL_IDLE;
        if (sub < acc_len - 1) begin
            c.ce_n = 1'b0;
            c.oe_n = 1'b0;
        end
        if (sub == acc_len - 2) c.latch = 1'b1;
        return c;
    endfunction

    // Mux held for the whole access, write strobes only in the middle.
    function automatic scan_ctrl_t key_capture_ctrl(int sub, int acc_len);
        scan_ctrl_t c;
        c = CTRL_IDLE;
        c.mux_en = 1'b1;
        if (sub > 0 && sub < acc_len - 1) begin
            c.ce_n = 1'b0;
            c.we_n = 1'b0;
        end
        return c;
    endfunction

    // Latch with the RAM parked, so the latch bus carries zeros.
    function automatic scan_ctrl_t lights_off_ctrl(int sub, int acc_len);
        scan_ctrl_t c;
        c = CTRL_IDLE;
        if (sub == acc_len - 2) c.latch = 1'b1;
        return c;
    endfunction

    function automatic scan_ctrl_t end_ctrl();
        scan_ctrl_t c;
        c = CTRL_IDLE;
        c.step_rst = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/scan_step_counter.sv
module scan_step_counter #(
    parameter int TOTAL  = 793,
    parameter int N_COLS = 48,
    parameter int SW     = 10,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_release,
    output logic [SW-1:0] step_o,
    output logic [CW-1:0] col_o,
    output logic          run_o,
    output logic          last_o
);
    localparam logic [SW-1:0] LAST_STEP = SW'(TOTAL - 1);
    localparam logic [CW-1:0] LAST_COL  = CW'(N_COLS - 1);

    logic [SW-1:0] step_q;
    logic [CW-1:0] col_q;
    logic          run_q;
    logic          at_end;

    assign at_end = run_q && (step_q == LAST_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            step_q <= '0;
            col_q  <= '0;
        end else if (!run_q) begin
            if (host_release) begin
                run_q  <= 1'b1;
                step_q <= '0;
                col_q  <= '0;
            end
        end else if (at_end) begin
            step_q <= '0;
            if (col_q == LAST_COL) begin
                run_q <= 1'b0;
                col_q <= '0;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end else begin
            step_q <= step_q + 1'b1;
        end
    end

    assign step_o = step_q;
    assign col_o  = col_q;
    assign run_o  = run_q;
    assign last_o = at_end && (col_q == LAST_COL);
endmodule

// File: rtl/scan_pattern_decode.sv
module scan_pattern_decode
    import scan_seq_pkg::*;
#(
    parameter int N_SUB       = 6,
    parameter int N_SUBSUB    = 8,
    parameter int ACC_LEN     = 4,
    parameter int PAD_STEPS   = 8,
    parameter int DWELL_STEPS = 640,
    parameter int SW          = 10,
    parameter int SUBW        = 3,
    parameter int PW          = 2,
    parameter int SSW         = 3,
    parameter int KIW         = 5
) (
    input  logic            run_i,
    input  logic [SW-1:0]   step_i,
    output scan_phase_e     phase_o,
    output scan_ctrl_t      ctrl_o,
    output logic [SUBW-1:0] sub_o,
    output logic [PW-1:0]   pair_o,
    output logic [SSW-1:0]  subsub_o,
    output logic [KIW-1:0]  key_idx_o
);
    localparam int KEY_READS = (N_SUB / 2) * N_SUBSUB;
    localparam int LED_END   = N_SUB * ACC_LEN;
    localparam int KEY_END   = LED_END + KEY_READS * ACC_LEN;
    localparam int PAD_END   = KEY_END + PAD_STEPS;
    localparam int DWELL_END = PAD_END + DWELL_STEPS;
    localparam int OFF_END   = DWELL_END + N_SUB * ACC_LEN;

    int s;
    int rel;
    int idx;

    always_comb begin
        s         = int'(step_i);
        rel       = 0;
        idx       = 0;
        phase_o   = PH_HALT;
        ctrl_o    = CTRL_IDLE;
        sub_o     = '0;
        pair_o    = '0;
        subsub_o  = '0;
        key_idx_o = '0;
        if (run_i) begin
            if (s < LED_END) begin
                phase_o = PH_LED;
                idx     = s / ACC_LEN;
                sub_o   = SUBW'(idx);
                ctrl_o  = led_load_ctrl(s % ACC_LEN, ACC_LEN);
            end else if (s < KEY_END) begin
                phase_o   = PH_KEY;
                rel       = s - LED_END;
                idx       = rel / ACC_LEN;
                key_idx_o = KIW'(idx);
                pair_o    = PW'(idx / N_SUBSUB);
                subsub_o  = SSW'(idx % N_SUBSUB);
                ctrl_o    = key_capture_ctrl(rel % ACC_LEN, ACC_LEN);
            end else if (s < PAD_END) begin
                phase_o = PH_PAD;
            end else if (s < DWELL_END) begin
                phase_o = PH_DWELL;
            end else if (s < OFF_END) begin
                phase_o = PH_OFF;
                rel     = s - DWELL_END;
                idx     = rel / ACC_LEN;
                sub_o   = SUBW'(idx);
                ctrl_o  = lights_off_ctrl(rel % ACC_LEN, ACC_LEN);
            end else begin
                phase_o = PH_END;
                ctrl_o  = end_ctrl();
            end
        end
    end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen
    import scan_seq_pkg::*;
#(
    parameter int N_SUB     = 6,
    parameter int KEY_READS = 24,
    parameter int N_COLS    = 48,
    parameter int CW        = 6,
    parameter int SUBW      = 3,
    parameter int KIW       = 5,
    parameter int AW        = 11
) (
    input  scan_phase_e     phase_i,
    input  logic            ce_n_i,
    input  logic [CW-1:0]   col_i,
    input  logic [SUBW-1:0] sub_i,
    input  logic [KIW-1:0]  key_idx_i,
    output logic [AW-1:0]   addr_o
);
    localparam int KEY_BASE = N_COLS * N_SUB;

    int a;

    always_comb begin
        a = 0;
        if (!ce_n_i) begin
            if (phase_i == PH_LED)
                a = int'(col_i) * N_SUB + int'(sub_i);
            else if (phase_i == PH_KEY)
                a = KEY_BASE + int'(col_i) * KEY_READS + int'(key_idx_i);
        end
        addr_o = AW'(a);
    end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
    import scan_seq_pkg::*;
#(
    parameter int N_SUB       = 6,
    parameter int N_SUBSUB    = 8,
    parameter int ACC_LEN     = 4,
    parameter int PAD_STEPS   = 8,
    parameter int DWELL_STEPS = 640,
    parameter int N_COLS      = 48,
    parameter int CW          = $clog2(N_COLS + 1),
    parameter int AW          = $clog2(N_COLS * (N_SUB + (N_SUB / 2) * N_SUBSUB)),
    parameter int SUBW        = (N_SUB > 2) ? $clog2(N_SUB) : 1,
    parameter int PW          = (N_SUB / 2 > 1) ? $clog2(N_SUB / 2) : 1,
    parameter int SSW         = (N_SUBSUB > 1) ? $clog2(N_SUBSUB) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_release,
    output logic            ram_we_n,
    output logic            ram_ce_n,
    output logic            ram_oe_n,
    output logic            sub_latch,
    output logic            mux_en,
    output logic            step_rst,
    output logic [AW-1:0]   ram_addr,
    output logic [SUBW-1:0] sub_sel,
    output logic [PW-1:0]   pair_sel,
    output logic [SSW-1:0]  subsub_sel,
    output logic [CW-1:0]   col_idx,
    output logic [2:0]      phase,
    output logic            busy,
    output logic            cycle_done
);
    localparam int TOTAL     = sched_len(N_SUB, N_SUBSUB, ACC_LEN, PAD_STEPS, DWELL_STEPS);
    localparam int SW        = $clog2(TOTAL);
    localparam int KEY_READS = (N_SUB / 2) * N_SUBSUB;
    localparam int KIW       = (KEY_READS > 1) ? $clog2(KEY_READS) : 1;

    logic [SW-1:0]  step_w;
    logic [CW-1:0]  col_w;
    logic           run_w;
    logic           last_w;
    scan_phase_e    phase_w;
    scan_ctrl_t     ctrl_w;
    logic [KIW-1:0] key_idx_w;

    scan_step_counter #(
        .TOTAL(TOTAL), .N_COLS(N_COLS), .SW(SW), .CW(CW)
    ) u_cnt (
        .clk(clk), .rst(rst), .host_release(host_release),
        .step_o(step_w), .col_o(col_w), .run_o(run_w), .last_o(last_w)
    );

    scan_pattern_decode #(
        .N_SUB(N_SUB), .N_SUBSUB(N_SUBSUB), .ACC_LEN(ACC_LEN),
        .PAD_STEPS(PAD_STEPS), .DWELL_STEPS(DWELL_STEPS), .SW(SW),
        .SUBW(SUBW), .PW(PW), .SSW(SSW), .KIW(KIW)
    ) u_dec (
        .run_i(run_w), .step_i(step_w), .phase_o(phase_w), .ctrl_o(ctrl_w),
        .sub_o(sub_sel), .pair_o(pair_sel), .subsub_o(subsub_sel),
        .key_idx_o(key_idx_w)
    );

    scan_addr_gen #(
        .N_SUB(N_SUB), .KEY_READS(KEY_READS), .N_COLS(N_COLS), .CW(CW),
        .SUBW(SUBW), .KIW(KIW), .AW(AW)
    ) u_addr (
        .phase_i(phase_w), .ce_n_i(ctrl_w.ce_n), .col_i(col_w),
        .sub_i(sub_sel), .key_idx_i(key_idx_w), .addr_o(ram_addr)
    );

    assign ram_we_n   = ctrl_w.we_n;
    assign ram_ce_n   = ctrl_w.ce_n;
    assign ram_oe_n   = ctrl_w.oe_n;
    assign sub_latch  = ctrl_w.latch;
    assign mux_en     = ctrl_w.mux_en;
    assign step_rst   = ctrl_w.step_rst;
    assign col_idx    = col_w;
    assign phase      = phase_w;
    assign busy       = run_w;
    assign cycle_done = last_w;
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk
    import scan_seq_pkg::*;
#(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          host_release,
    input logic          ram_we_n,
    input logic          ram_ce_n,
    input logic          ram_oe_n,
    input logic          sub_latch,
    input logic          mux_en,
    input logic          step_rst,
    input logic [CW-1:0] col_idx,
    input logic [2:0]    phase,
    input logic          busy,
    input logic          cycle_done
);
    a_r1_next_column: assert property (@(posedge clk) disable iff (rst)
        (step_rst && !cycle_done) |=> (phase == PH_LED && busy));

    a_r2_led_no_write: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LED) |-> ram_we_n);

    a_r3_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !ram_we_n |-> !ram_ce_n);

    a_r4_key_mux_no_oe: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_KEY) |-> (mux_en && ram_oe_n));

    a_r5_dwell_quiet: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DWELL || phase == PH_PAD) |->
            (ram_ce_n && ram_we_n && ram_oe_n && !sub_latch && !mux_en));

    a_r6_off_ram_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_OFF) |-> (ram_ce_n && ram_oe_n && ram_we_n));

    a_r7_rst_only_end: assert property (@(posedge clk) disable iff (rst)
        step_rst |-> (phase == PH_END));

    a_r9_done_halts: assert property (@(posedge clk) disable iff (rst)
        cycle_done |=> (!busy && col_idx == '0));

    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ram_ce_n && ram_we_n && ram_oe_n && !sub_latch &&
                   !mux_en && !step_rst && !cycle_done));

    a_r10_release_starts: assert property (@(posedge clk) disable iff (rst)
        (!busy && host_release) |=> (busy && phase == PH_LED && col_idx == '0));

    a_r10_release_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_rst) |=> $stable(col_idx));
endmodule

bind scan_sequencer scan_sequencer_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .host_release(host_release),
    .ram_we_n(ram_we_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .sub_latch(sub_latch), .mux_en(mux_en), .step_rst(step_rst),
    .col_idx(col_idx), .phase(phase), .busy(busy), .cycle_done(cycle_done)
);

// File: tb/scan_sequencer_tb.sv
module scan_sequencer_tb;
    localparam int NC   = 3;
    localparam int CW   = $clog2(NC + 1);
    localparam int AW   = $clog2(NC * 30);
    localparam int LAST = 792;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_release = 1'b0;
    logic          ram_we_n, ram_ce_n, ram_oe_n, sub_latch, mux_en, step_rst;
    logic [AW-1:0] ram_addr;
    logic [2:0]    sub_sel;
    logic [1:0]    pair_sel;
    logic [2:0]    subsub_sel;
    logic [CW-1:0] col_idx;
    logic [2:0]    phase;
    logic          busy, cycle_done;

    int n_checks = 0;
    int n_fails  = 0;
    int m_step   = 0;
    int m_col    = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    scan_sequencer #(.N_COLS(NC)) u_dut (
        .clk(clk), .rst(rst), .host_release(host_release),
        .ram_we_n(ram_we_n), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
        .sub_latch(sub_latch), .mux_en(mux_en), .step_rst(step_rst),
        .ram_addr(ram_addr), .sub_sel(sub_sel), .pair_sel(pair_sel),
        .subsub_sel(subsub_sel), .col_idx(col_idx), .phase(phase),
        .busy(busy), .cycle_done(cycle_done)
    );

    // {step, phase, ctrl = {we_n, ce_n, oe_n, latch, mux, step_rst}}
    localparam int NV = 20;
    localparam logic [18:0] VEC [NV] = '{
        {10'd0,   3'd1, 6'b100000}, {10'd2,   3'd1, 6'b100100},
        {10'd3,   3'd1, 6'b111000}, {10'd22,  3'd1, 6'b100100},
        {10'd23,  3'd1, 6'b111000}, {10'd24,  3'd2, 6'b111010},
        {10'd25,  3'd2, 6'b001010}, {10'd26,  3'd2, 6'b001010},
        {10'd27,  3'd2, 6'b111010}, {10'd118, 3'd2, 6'b001010},
        {10'd119, 3'd2, 6'b111010}, {10'd120, 3'd3, 6'b111000},
        {10'd127, 3'd3, 6'b111000}, {10'd128, 3'd4, 6'b111000},
        {10'd767, 3'd4, 6'b111000}, {10'd768, 3'd5, 6'b111000},
        {10'd770, 3'd5, 6'b111100}, {10'd790, 3'd5, 6'b111100},
        {10'd791, 3'd5, 6'b111000}, {10'd792, 3'd6, 6'b111001}
    };

    function automatic logic [5:0] ctrl_now();
        return {ram_we_n, ram_ce_n, ram_oe_n, sub_latch, mux_en, step_rst};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at col %0d step %0d: actual %0d expected %0d",
                     req, m_col, m_step, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (m_step == LAST) begin
            m_step = 0;
            m_col++;
        end else begin
            m_step++;
        end
    endtask

    task automatic adv_to(input int col, input int step);
        while (!(m_col == col && m_step == step)) tick();
    endtask

    task automatic release_pulse();
        host_release = 1'b1;
        @(negedge clk);
        host_release = 1'b0;
        m_step = 0;
        m_col  = 0;
    endtask

    task automatic chk_halted(input string req);
        chk(busy == 1'b0, req, int'(busy), 0);
        chk(phase == 3'd0, req, int'(phase), 0);
        chk(ctrl_now() == 6'b111000, req, int'(ctrl_now()), 6'b111000);
        chk(col_idx == '0 && cycle_done == 1'b0, req, int'(col_idx), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state
        @(negedge clk);
        chk_halted("R11 reset");
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk_halted("R9 halted before release");

        // R10: start
        release_pulse();
        chk(busy == 1'b1 && col_idx == '0, "R10 start", int'(busy), 1);

        // Table walk over column 0 (R2 R3 R4 R5 R6 R7 R12)
        for (int i = 0; i < NV; i++) begin
            adv_to(0, int'(VEC[i][18:9]));
            chk(ctrl_now() == VEC[i][5:0], "R2-R7 ctrl word", int'(ctrl_now()), int'(VEC[i][5:0]));
            chk(phase == VEC[i][8:6], "R12 phase", int'(phase), int'(VEC[i][8:6]));
        end
        chk(cycle_done == 1'b0, "R9 no done mid frame", int'(cycle_done), 0);

        // R1: next column follows step 792
        tick();
        chk(col_idx == CW'(1) && phase == 3'd1, "R1 column advance", int'(col_idx), 1);

        // R8 / R2: indicator addresses in column 1
        adv_to(1, 2);
        chk(ram_addr == AW'(6) && sub_sel == 3'd0, "R8 led addr k0", int'(ram_addr), 6);
        adv_to(1, 22);
        chk(ram_addr == AW'(11) && sub_sel == 3'd5, "R8 led addr k5", int'(ram_addr), 11);

        // R10: release while running is ignored
        adv_to(1, 30);
        host_release = 1'b1;
        tick(); tick(); tick();
        host_release = 1'b0;

        // R4 / R8: read 13 -> pair 1, sub-substation 5, addr 18+24+13
        adv_to(1, 77);
        chk(col_idx == CW'(1) && phase == 3'd2, "R10 release ignored", int'(col_idx), 1);
        chk(pair_sel == 2'd1 && subsub_sel == 3'd5, "R4 pair/subsub", int'(pair_sel), 1);
        chk(ram_addr == AW'(55) && ram_ce_n == 1'b0, "R8 key addr", int'(ram_addr), 55);

        // R6: lights-off substation select
        adv_to(1, 770);
        chk(sub_sel == 3'd0 && sub_latch == 1'b1, "R6 off k0", int'(sub_sel), 0);
        adv_to(1, 790);
        chk(sub_sel == 3'd5 && ram_ce_n == 1'b1, "R6 off k5", int'(sub_sel), 5);
        adv_to(1, LAST);
        chk(cycle_done == 1'b0 && step_rst == 1'b1, "R9 done not before last col", int'(cycle_done), 0);

        // R9: end of frame
        adv_to(2, LAST);
        chk(cycle_done == 1'b1 && step_rst == 1'b1, "R9 cycle_done", int'(cycle_done), 1);
        @(negedge clk);
        chk_halted("R9 halt after frame");
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk_halted("R9 stays halted");

        // R10: restart, then R11 mid-run reset
        release_pulse();
        chk(phase == 3'd1 && ram_ce_n == 1'b0, "R10 restart step0", int'(phase), 1);
        adv_to(0, 10);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_halted("R11 reset while running");
        release_pulse();
        tick();
        chk(phase == 3'd1 && col_idx == '0 && busy == 1'b1, "R11 recover", int'(phase), 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule